// File: doc/BRIEF.md
# Serial Channel Diagnostic Loopback Router

This block sits between the serial pins of a communications channel and its internal transmitter and receiver. A two-bit diagnostic mode decides where the receiver takes its data from and what drives the transmit pin. The four choices are plain pin operation, an internal loopback from transmitter to receiver, an automatic echo of received bits back onto the transmit pin, and loopback and echo together. The same mode decides which of the clear-to-send and carrier-detect inputs the controller sees as they are, and which it sees as forced asserted.

Separate receive and transmit enables gate the two directions. Software may change them at any time, with or without serial clocks, so they are synchronised into the system clock. When an enable falls, its direction goes to the idle line level of logic 1 and a one-cycle abort pulse tells the attached shifter to drop the character it is working on. The echo path samples the receive pin on each rising edge of the receive clock, after synchronising both into the system clock.

Mode bit 0 selects loopback and mode bit 1 selects echo. All modem-control levels are active high, where 1 means asserted.

Top module: `serdiag_router`

## Requirements
- R1: Mode 00: `rx_data_in` follows `pin_rxd`, `pin_txd` follows `tx_data`, `eff_cts` equals `pin_cts`, and `eff_cd` equals `pin_cd`, with both enables active.
- R2: When mode bit 0 is set (01 or 11), `rx_data_in` follows the transmit line and ignores `pin_rxd`, and `eff_cts` and `eff_cd` are both 1 whatever the pins show.
- R3: Mode 01: `pin_txd` carries the transmit line when `loop_txd_high` is 0 and is held at 1 when it is 1.
- R4: When mode bit 1 is set, `pin_txd` shows the echo bit. The echo bit is the value of `pin_rxd` taken at the most recent rising edge of `rx_clk`. It holds between edges and is 1 after reset.
- R5: Mode 10: `eff_cts` is 1, `eff_cd` equals `pin_cd`, and `rx_data_in` follows `pin_rxd`.
- R6: Mode 11: `rx_data_in` follows the transmit line, `pin_txd` shows the echo bit, and `eff_cts` and `eff_cd` are both 1.
- R7: While the synchronised receive enable is low, `rx_data_in` is 1. A falling receive enable gives one pulse on `rx_abort`.
- R8: While the synchronised transmit enable is low, the transmit line is 1, so `pin_txd` is 1 in modes 00 and 01. A falling transmit enable gives one pulse on `tx_abort`.
- R9: Each enable passes through SYNC_STAGES flops. An abort pulse is high for exactly one cycle, in the cycle after the SYNC_STAGES-th rising clock edge that follows the fall. A rising enable gives no pulse.
- R10: During and after reset, with enables low: `pin_txd` is 1, `rx_data_in` is 1, and both abort outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| diag_mode | input | 2 | Bit 0 selects loopback, bit 1 selects echo |
| rx_en | input | 1 | Receive enable, asynchronous |
| tx_en | input | 1 | Transmit enable, asynchronous |
| loop_txd_high | input | 1 | In loopback, hold the transmit pin at 1 |
| pin_rxd | input | 1 | Receive data pin |
| pin_cts | input | 1 | Clear-to-send pin, 1 = asserted |
| pin_cd | input | 1 | Carrier-detect pin, 1 = asserted |
| rx_clk | input | 1 | Receive bit clock, asynchronous |
| tx_data | input | 1 | Serial output of the internal transmitter |
| pin_txd | output | 1 | Transmit data pin |
| rx_data_in | output | 1 | Serial input to the internal receiver |
| eff_cts | output | 1 | Clear-to-send as the controller sees it |
| eff_cd | output | 1 | Carrier-detect as the controller sees it |
| rx_abort | output | 1 | One-cycle pulse when the receive enable falls |
| tx_abort | output | 1 | One-cycle pulse when the transmit enable falls |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that value the abort pulse lands in a cycle the bench can predict by counting edges, and the echo path settles within a few cycles of each receive-clock edge. This lets the bench check the exact cycle of each abort pulse and confirm that the echo bit holds while `pin_rxd` moves between clock edges. It runs all four modes with the control pins driven opposite to their forced values, so any leak of a pin through a forced path shows up at the outputs.

// File: rtl/serdiag_pkg.sv
// Package: shared mode type for the diagnostic router.
// Assumes mode bit 0 = loopback, bit 1 = echo; the two combine freely.
package serdiag_pkg;

    typedef struct packed {
        logic echo;   // bit 1: retransmit received bits on the transmit pin
        logic loop;   // bit 0: transmitter feeds receiver internally
    } diag_mode_t;

    localparam logic IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/serdiag_sync.sv
// Multi-bit, per-bit level synchroniser. Each bit passes through STAGES
// flops. Assumes every bit is an independent, slowly changing level.
module serdiag_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First capture stage from the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= d;
                end
            end else begin : g_next
                // Further settling stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/serdiag_fall.sv
// Falling-edge pulse generator for a synchronised enable level.
// Assumes the level is already in the clk domain.
module serdiag_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic prev_q;

    // Remember the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign pulse = prev_q & ~level;

    p_abort_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    p_abort_level_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !level);

endmodule

// File: rtl/serdiag_echo.sv
// Echo capture: takes the synchronised receive pin on each rising edge of
// the synchronised receive clock. Assumes both inputs come through matching
// synchroniser depths, so they stay aligned.
module serdiag_echo (
    input  logic clk,
    input  logic rst_n,
    input  logic rclk_s,
    input  logic rxd_s,
    output logic echo_bit
);

    logic rclk_prev_q;
    logic echo_q;
    logic rise;

    assign rise = rclk_s & ~rclk_prev_q;

    // Track the receive clock for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rclk_prev_q <= 1'b0;
        else        rclk_prev_q <= rclk_s;
    end

    // Capture the received bit at each receive-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)    echo_q <= serdiag_pkg::IDLE_LEVEL;
        else if (rise) echo_q <= rxd_s;
    end

    assign echo_bit = echo_q;

    p_echo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(echo_bit));

    p_echo_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> echo_bit == $past(rxd_s));

endmodule

// File: rtl/serdiag_mux.sv
// Routing and gating network. Selects the receiver source, the transmit pin
// driver and the effective modem controls from the mode. Purely
// combinational; clk/rst_n serve only the guarding assertions.
module serdiag_mux
    import serdiag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  diag_mode_t mode,
    input  logic       rx_en_q,
    input  logic       tx_en_q,
    input  logic       loop_txd_high,
    input  logic       pin_rxd,
    input  logic       pin_cts,
    input  logic       pin_cd,
    input  logic       tx_data,
    input  logic       echo_bit,
    output logic       pin_txd,
    output logic       rx_data_in,
    output logic       eff_cts,
    output logic       eff_cd
);

    logic tx_line;
    logic rx_src;

    // Transmit line: idle whenever the transmitter is disabled
    always_comb tx_line = tx_en_q ? tx_data : IDLE_LEVEL;

    // Receiver source: internal loop or pin, idle when receiver disabled
    always_comb begin
        rx_src     = mode.loop ? tx_line : pin_rxd;
        rx_data_in = rx_en_q ? rx_src : IDLE_LEVEL;
    end

    // Transmit pin driver: echo wins, else optional forced-high in loopback
    always_comb begin
        if (mode.echo)                     pin_txd = echo_bit;
        else if (mode.loop && loop_txd_high) pin_txd = IDLE_LEVEL;
        else                               pin_txd = tx_line;
    end

    // Modem controls: loopback forces both, echo alone forces only CTS
    always_comb begin
        eff_cts = (mode.loop | mode.echo) ? 1'b1 : pin_cts;
        eff_cd  = mode.loop ? 1'b1 : pin_cd;
    end

    p_rx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q |-> rx_data_in);

    p_tx_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_q && !mode.echo) |-> pin_txd);

    p_loop_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode.loop |-> (eff_cts && eff_cd));

    p_echo_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mode.echo |-> (pin_txd == echo_bit));

endmodule

// File: rtl/serdiag_router.sv
// Top: serial channel diagnostic loopback router. Synchronises the two
// enables and the echo inputs, generates abort pulses and routes data and
// modem controls by diagnostic mode. Assumes rx_clk is much slower than clk.
module serdiag_router #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] diag_mode,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       loop_txd_high,
    input  logic       pin_rxd,
    input  logic       pin_cts,
    input  logic       pin_cd,
    input  logic       rx_clk,
    input  logic       tx_data,
    output logic       pin_txd,
    output logic       rx_data_in,
    output logic       eff_cts,
    output logic       eff_cd,
    output logic       rx_abort,
    output logic       tx_abort
);

    import serdiag_pkg::*;

    localparam int NSYNC = 4;
    // Bit order: {rxd, rx_clk, tx_en, rx_en}; rxd resets to idle level
    localparam logic [NSYNC-1:0] SYNC_RST = {IDLE_LEVEL, 3'b000};

    logic [NSYNC-1:0] sync_q;
    logic             rx_en_q, tx_en_q, rclk_s, rxd_s;
    logic             echo_bit;
    diag_mode_t       mode;

    assign mode = diag_mode_t'(diag_mode);

    serdiag_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pin_rxd, rx_clk, tx_en, rx_en}),
        .q     (sync_q)
    );

    assign {rxd_s, rclk_s, tx_en_q, rx_en_q} = sync_q;

    serdiag_fall u_rx_fall (.clk(clk), .rst_n(rst_n), .level(rx_en_q), .pulse(rx_abort));
    serdiag_fall u_tx_fall (.clk(clk), .rst_n(rst_n), .level(tx_en_q), .pulse(tx_abort));

    serdiag_echo u_echo (
        .clk      (clk),
        .rst_n    (rst_n),
        .rclk_s   (rclk_s),
        .rxd_s    (rxd_s),
        .echo_bit (echo_bit)
    );

    serdiag_mux u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .rx_en_q       (rx_en_q),
        .tx_en_q       (tx_en_q),
        .loop_txd_high (loop_txd_high),
        .pin_rxd       (pin_rxd),
        .pin_cts       (pin_cts),
        .pin_cd        (pin_cd),
        .tx_data       (tx_data),
        .echo_bit      (echo_bit),
        .pin_txd       (pin_txd),
        .rx_data_in    (rx_data_in),
        .eff_cts       (eff_cts),
        .eff_cd        (eff_cd)
    );

    p_no_abort_when_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_q && tx_en_q) |-> (!rx_abort && !tx_abort));

    p_echo_cts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_mode == 2'b10) |-> (eff_cts && eff_cd == pin_cd));

endmodule

// File: tb/serdiag_router_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module serdiag_router_tb;

    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] diag_mode = 2'b00;
    logic rx_en = 1'b0, tx_en = 1'b0, loop_txd_high = 1'b0;
    logic pin_rxd = 1'b1, pin_cts = 1'b0, pin_cd = 1'b0, rx_clk = 1'b0, tx_data = 1'b1;
    logic pin_txd, rx_data_in, eff_cts, eff_cd, rx_abort, tx_abort;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serdiag_router #(.SYNC_STAGES(STG)) u_dut (
        .clk(clk), .rst_n(rst_n), .diag_mode(diag_mode), .rx_en(rx_en), .tx_en(tx_en),
        .loop_txd_high(loop_txd_high), .pin_rxd(pin_rxd), .pin_cts(pin_cts), .pin_cd(pin_cd),
        .rx_clk(rx_clk), .tx_data(tx_data), .pin_txd(pin_txd), .rx_data_in(rx_data_in),
        .eff_cts(eff_cts), .eff_cd(eff_cd), .rx_abort(rx_abort), .tx_abort(tx_abort)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        settle(3);
        chk("R10", "txd in reset", pin_txd, 1'b1);
        chk("R10", "rx_data_in in reset", rx_data_in, 1'b1);
        chk("R10", "rx_abort in reset", rx_abort, 1'b0);
        chk("R10", "tx_abort in reset", tx_abort, 1'b0);
        rst_n = 1'b1;
        settle(3);
        chk("R10", "txd after reset", pin_txd, 1'b1);
        chk("R10", "tx_abort after reset", tx_abort, 1'b0);
    endtask

    task automatic t_enable_rise();
        @(negedge clk);
        rx_en = 1'b1; tx_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #2;
            chk("R9", "no rx_abort on rise", rx_abort, 1'b0);
            chk("R9", "no tx_abort on rise", tx_abort, 1'b0);
        end
    endtask

    task automatic t_normal();
        diag_mode = 2'b00;
        for (int v = 0; v < 4; v++) begin
            pin_rxd = v[0]; tx_data = ~v[0]; pin_cts = v[1]; pin_cd = ~v[1];
            #2;
            chk("R1", "rx_data_in", rx_data_in, pin_rxd);
            chk("R1", "txd", pin_txd, tx_data);
            chk("R1", "eff_cts", eff_cts, pin_cts);
            chk("R1", "eff_cd", eff_cd, pin_cd);
            settle(1);
        end
    endtask

    task automatic t_loop();
        diag_mode = 2'b01; pin_cts = 1'b0; pin_cd = 1'b0;
        for (int v = 0; v < 4; v++) begin
            tx_data = v[0]; pin_rxd = ~v[0]; loop_txd_high = v[1];
            #2;
            chk("R2", "rx follows tx", rx_data_in, v[0]);
            chk("R2", "eff_cts forced", eff_cts, 1'b1);
            chk("R2", "eff_cd forced", eff_cd, 1'b1);
            chk("R3", "loop txd", pin_txd, v[1] ? 1'b1 : v[0]);
            settle(1);
        end
        loop_txd_high = 1'b0;
    endtask

    task automatic rclk_pulse(input logic bitv);
        pin_rxd = bitv;
        settle(4);
        rx_clk = 1'b1;
        settle(5);
        rx_clk = 1'b0;
        settle(5);
    endtask

    task automatic t_echo();
        diag_mode = 2'b10; tx_data = 1'b0;
        #2;
        chk("R4", "echo reset value", pin_txd, 1'b1);
        rclk_pulse(1'b0);
        chk("R4", "echo captured 0", pin_txd, 1'b0);
        pin_rxd = 1'b1;
        settle(6);
        chk("R4", "echo holds without edge", pin_txd, 1'b0);
        rclk_pulse(1'b1);
        chk("R4", "echo captured 1", pin_txd, 1'b1);
        pin_cts = 1'b0; pin_cd = 1'b0; pin_rxd = 1'b0;
        #2;
        chk("R5", "eff_cts forced", eff_cts, 1'b1);
        chk("R5", "eff_cd follows pin 0", eff_cd, 1'b0);
        chk("R5", "rx from pin 0", rx_data_in, 1'b0);
        pin_cd = 1'b1; pin_rxd = 1'b1;
        #2;
        chk("R5", "eff_cd follows pin 1", eff_cd, 1'b1);
        chk("R5", "rx from pin 1", rx_data_in, 1'b1);
        settle(1);
    endtask

    task automatic t_both();
        diag_mode = 2'b11; pin_cts = 1'b0; pin_cd = 1'b0;
        rclk_pulse(1'b0);
        pin_rxd = 1'b1; tx_data = 1'b0;
        #2;
        chk("R6", "rx follows tx 0", rx_data_in, 1'b0);
        chk("R6", "txd echo", pin_txd, 1'b0);
        chk("R6", "eff_cts forced", eff_cts, 1'b1);
        chk("R6", "eff_cd forced", eff_cd, 1'b1);
        tx_data = 1'b1; pin_rxd = 1'b0;
        #2;
        chk("R6", "rx follows tx 1", rx_data_in, 1'b1);
        settle(1);
    endtask

    task automatic t_tx_disable();
        diag_mode = 2'b00; tx_data = 1'b0;
        @(negedge clk);
        tx_en = 1'b0;
        for (int i = 0; i < STG; i++) @(posedge clk);
        @(negedge clk); #2;
        chk("R9", "tx_abort at sync depth", tx_abort, 1'b1);
        chk("R8", "txd idle when off", pin_txd, 1'b1);
        @(negedge clk); #2;
        chk("R9", "tx_abort one cycle", tx_abort, 1'b0);
        diag_mode = 2'b01; #2;
        chk("R8", "loop rx sees idle tx", rx_data_in, 1'b1);
        chk("R8", "loop txd idle", pin_txd, 1'b1);
        diag_mode = 2'b00;
        tx_en = 1'b1;
        settle(4);
    endtask

    task automatic t_rx_disable();
        diag_mode = 2'b00; pin_rxd = 1'b0;
        @(negedge clk);
        rx_en = 1'b0;
        for (int i = 0; i < STG; i++) @(posedge clk);
        @(negedge clk); #2;
        chk("R7", "rx_abort pulse", rx_abort, 1'b1);
        chk("R7", "rx idle when off", rx_data_in, 1'b1);
        chk("R8", "no tx_abort", tx_abort, 1'b0);
        @(negedge clk); #2;
        chk("R9", "rx_abort one cycle", rx_abort, 1'b0);
        rx_en = 1'b1;
        settle(4);
        chk("R7", "rx back on", rx_data_in, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_rise();
        t_normal();
        t_loop();
        t_echo();
        t_both();
        t_tx_disable();
        t_rx_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule